// File: doc/BRIEF.md
# Sector Channel Byte Input Port

This block takes coded bytes from a disc channel decoder. The sender drives an 8-bit bus, a qualifier and a sector-start marker, all timed by the sender's own data clock. The port keeps each accepted byte together with a one-bit sector-start tag. It stores the pair in a 64-entry asynchronous FIFO and hands it to the system clock domain through a valid/ready output. A flow-control request line tells the sender when to pause. It goes low when the on-chip buffer nears full, or when the downstream memory channel reports that it is full.

A three-state write-side machine decides whether each qualified byte is kept. In `ST_HUNT`, the state after reset, bytes are thrown away until a byte marked as a sector start arrives while there is room. That byte is stored and the machine moves to `ST_PASS`. In `ST_PASS`, every qualified byte is stored. A qualified byte that finds the FIFO full is dropped and moves the machine to `ST_SKIP`. In `ST_SKIP`, the rest of the damaged sector is thrown away. A sector-start byte that arrives while there is room is stored and returns the machine to `ST_PASS`. Every byte dropped because the FIFO was full sets a sticky overflow flag. Only an explicit clear pulse in the system domain resets it.

Top module: `sector_chan_port`

## Requirements
- R1: A byte on `chan_data` is taken on a rising `chan_clk` edge only when `chan_qual` equals `cfg_qual_high`. With `cfg_qual_high`=1 the qualifier is active high, and with 0 it is active low. Cycles without the active qualifier leave nothing in the FIFO.
- R2: After reset, qualified bytes are discarded until a qualified byte arrives with `chan_sos`=1. That byte is the first one stored.
- R3: Stored bytes leave on `out_data` in arrival order. `out_sos` is 1 exactly for the bytes that were taken with `chan_sos`=1.
- R4: The FIFO holds 64 bytes. A qualified byte that arrives while 64 are held is dropped, and `ovf_flag` becomes 1.
- R5: After a drop, further qualified bytes without `chan_sos` are discarded, even when room is available. The next qualified sector-start byte that finds room is stored, and storing resumes from there.
- R6: `ovf_flag` stays 1 until a one-cycle pulse on `ovf_clear`, after which it reads 0.
- R7: `chan_req` is 0 when the write-side occupancy is 60 bytes or more, and 1 below that, as long as `mem_full` is 0. It follows a write on the next `chan_clk` edge.
- R8: While `mem_full` is 1, `chan_req` is 0. It returns to 1 once `mem_full` falls and the occupancy is below 60.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_sos` hold their values.
- R10: After reset, `out_valid`=0, `ovf_flag`=0 and `chan_req`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| chan_clk | input | 1 | Sender data clock |
| chan_data | input | 8 | Coded byte from the sender |
| chan_qual | input | 1 | Byte qualifier, active level set by `cfg_qual_high` |
| chan_sos | input | 1 | Marks the first byte of a sector |
| chan_req | output | 1 | Flow-control request to the sender (chan_clk domain) |
| sys_clk | input | 1 | System clock |
| cfg_qual_high | input | 1 | Qualifier polarity: 1 = active high, 0 = active low |
| mem_full | input | 1 | Downstream memory channel full (sys_clk domain) |
| ovf_clear | input | 1 | One-cycle pulse that clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag (sys_clk domain) |
| out_valid | output | 1 | A stored byte is available |
| out_ready | input | 1 | Consumer takes the byte on this sys_clk edge |
| out_data | output | 8 | Stored byte |
| out_sos | output | 1 | Sector-start tag of the stored byte |

## Verification
A write moves `chan_req` one `chan_clk` edge after the byte is taken. A change on `mem_full` reaches `chan_req` after three `chan_clk` edges: two synchronizer stages and the request register. A stored byte appears on `out_valid` about three `sys_clk` edges after its write: the registered Gray pointer plus two synchronizer stages. `ovf_flag` follows a drop after two `sys_clk` edges. A clear takes about six edges across both domains. The bench drives inputs on falling edges and samples on falling edges only after idle windows longer than each of these latencies. It keeps `out_ready` low while it fills the buffer, so the occupancy the write side sees equals the count in the bench model when each fill check is made.

// File: rtl/sector_chan_pkg.sv
package sector_chan_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PASS = 2'd1,
        ST_SKIP = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic              sos;
        logic [BYTE_W-1:0] data;
    } chan_entry_t;

endpackage

// File: rtl/chan_bit_sync.sv
module chan_bit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/chan_gray_fifo.sv
module chan_gray_fifo #(
    parameter int AW          = 6,
    parameter int DW          = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    output logic [AW:0]   wlevel,
    input  logic          pop,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];

    logic [PW-1:0] wbin, wbin_nxt, wgray_q, wgray_rs;
    logic [PW-1:0] rbin, rbin_nxt, rgray_q, rgray_ws, rbin_ws;

    // write side
    assign wbin_nxt = wbin + PW'(push);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray_q <= '0;
        end else begin
            wbin    <= wbin_nxt;
            wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (push) begin
            mem[wbin[AW-1:0]] <= wdata;
        end
    end

    chan_bit_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk  (wclk),
        .rst_n(rst_n),
        .d    (rgray_q),
        .q    (rgray_ws)
    );

    genvar gi;
    generate
        for (gi = 0; gi < PW; gi++) begin : g_g2b
            assign rbin_ws[gi] = ^(rgray_ws >> gi);
        end
    endgenerate

    assign wlevel = wbin - rbin_ws;

    // read side
    assign rvalid   = (rgray_q != wgray_rs);
    assign rbin_nxt = rbin + PW'(pop && rvalid);
    assign rdata    = mem[rbin[AW-1:0]];

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray_q <= '0;
        end else begin
            rbin    <= rbin_nxt;
            rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    chan_bit_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk  (rclk),
        .rst_n(rst_n),
        .d    (wgray_q),
        .q    (wgray_rs)
    );
endmodule

// File: rtl/chan_wr_ctrl.sv
module chan_wr_ctrl
    import sector_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      sos,
    input  logic      full,
    output logic      push,
    output logic      drop,
    output wr_state_e state
);
    wr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_HUNT: if (hit && sos && !full) state_d = ST_PASS;
            ST_PASS: if (hit && full)         state_d = ST_SKIP;
            ST_SKIP: if (hit && sos && !full) state_d = ST_PASS;
            default:                          state_d = ST_HUNT;
        endcase
    end

    always_comb begin
        push = 1'b0;
        drop = hit && full;
        unique case (state)
            ST_HUNT, ST_SKIP: push = hit && sos && !full;
            ST_PASS:          push = hit && !full;
            default:          push = 1'b0;
        endcase
    end
endmodule

// File: rtl/sector_chan_port.sv
module sector_chan_port
    import sector_chan_pkg::*;
#(
    parameter int AW          = 6,
    parameter int HIGH_MARK   = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst_n,
    input  logic              chan_clk,
    input  logic [BYTE_W-1:0] chan_data,
    input  logic              chan_qual,
    input  logic              chan_sos,
    output logic              chan_req,
    input  logic              sys_clk,
    input  logic              cfg_qual_high,
    input  logic              mem_full,
    input  logic              ovf_clear,
    output logic              ovf_flag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sos
);
    localparam int DEPTH = 1 << AW;
    localparam int LW    = AW + 1;
    localparam int EW    = $bits(chan_entry_t);

    logic        chan_hit, chan_full, wr_push, wr_drop;
    logic [AW:0] chan_level;
    wr_state_e   wr_state;
    chan_entry_t wr_entry, rd_entry;

    logic ovf_q, mem_full_c, clr_tog, clr_tog_c, clr_tog_c_d, clr_pulse;

    assign chan_hit  = (chan_qual == cfg_qual_high);
    assign chan_full = (chan_level >= LW'(DEPTH));
    assign wr_entry  = '{sos: chan_sos, data: chan_data};

    chan_wr_ctrl u_ctrl (
        .clk  (chan_clk),
        .rst_n(rst_n),
        .hit  (chan_hit),
        .sos  (chan_sos),
        .full (chan_full),
        .push (wr_push),
        .drop (wr_drop),
        .state(wr_state)
    );

    chan_gray_fifo #(.AW(AW), .DW(EW), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
        .wclk  (chan_clk),
        .rclk  (sys_clk),
        .rst_n (rst_n),
        .push  (wr_push),
        .wdata (wr_entry),
        .wlevel(chan_level),
        .pop   (out_ready),
        .rvalid(out_valid),
        .rdata (rd_entry)
    );

    assign out_data = rd_entry.data;
    assign out_sos  = rd_entry.sos;

    // flow control in the sender domain
    chan_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_mfull_sync (
        .clk  (chan_clk),
        .rst_n(rst_n),
        .d    (mem_full),
        .q    (mem_full_c)
    );

    always_ff @(posedge chan_clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_req <= 1'b1;
        end else begin
            chan_req <= (chan_level < LW'(HIGH_MARK)) && !mem_full_c;
        end
    end

    // overflow flag: set in sender domain, cleared from system domain
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_tog <= 1'b0;
        end else if (ovf_clear) begin
            clr_tog <= ~clr_tog;
        end
    end

    chan_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_clr_sync (
        .clk  (chan_clk),
        .rst_n(rst_n),
        .d    (clr_tog),
        .q    (clr_tog_c)
    );

    always_ff @(posedge chan_clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_tog_c_d <= 1'b0;
        end else begin
            clr_tog_c_d <= clr_tog_c;
        end
    end

    assign clr_pulse = clr_tog_c ^ clr_tog_c_d;

    always_ff @(posedge chan_clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (wr_drop) begin
            ovf_q <= 1'b1;
        end else if (clr_pulse) begin
            ovf_q <= 1'b0;
        end
    end

    chan_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf_sync (
        .clk  (sys_clk),
        .rst_n(rst_n),
        .d    (ovf_q),
        .q    (ovf_flag)
    );
endmodule

// File: rtl/sector_chan_port_chk.sv
module sector_chan_port_chk
    import sector_chan_pkg::*;
#(
    parameter int AW        = 6,
    parameter int HIGH_MARK = 60
) (
    input logic              rst_n,
    input logic              chan_clk,
    input logic              sys_clk,
    input logic [AW:0]       chan_level,
    input logic              wr_push,
    input logic              wr_drop,
    input logic              ovf_q,
    input logic              chan_req,
    input wr_state_e         wr_state,
    input logic              chan_qual,
    input logic              cfg_qual_high,
    input logic              chan_sos,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_sos
);
    localparam int DEPTH = 1 << AW;

    // R4
    level_bound_chk: assert property (@(posedge chan_clk) disable iff (!rst_n)
        chan_level <= (AW+1)'(DEPTH));

    // R7
    req_off_chk: assert property (@(posedge chan_clk) disable iff (!rst_n)
        chan_level >= (AW+1)'(HIGH_MARK) |=> !chan_req);

    // R4
    ovf_set_chk: assert property (@(posedge chan_clk) disable iff (!rst_n)
        wr_drop |=> ovf_q);

    // R2
    hunt_hold_chk: assert property (@(posedge chan_clk) disable iff (!rst_n)
        (wr_state == ST_HUNT && !chan_sos) |-> !wr_push);

    // R1
    qual_gate_chk: assert property (@(posedge chan_clk) disable iff (!rst_n)
        (chan_qual != cfg_qual_high) |-> (!wr_push && !wr_drop));

    // R9
    out_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_sos, out_data})));
endmodule

bind sector_chan_port sector_chan_port_chk #(.AW(AW), .HIGH_MARK(HIGH_MARK)) u_chk (
    .rst_n        (rst_n),
    .chan_clk     (chan_clk),
    .sys_clk      (sys_clk),
    .chan_level   (chan_level),
    .wr_push      (wr_push),
    .wr_drop      (wr_drop),
    .ovf_q        (ovf_q),
    .chan_req     (chan_req),
    .wr_state     (wr_state),
    .chan_qual    (chan_qual),
    .cfg_qual_high(cfg_qual_high),
    .chan_sos     (chan_sos),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_sos      (out_sos)
);

// File: tb/test_sector_chan_port.sv
module test_sector_chan_port;
    logic       rst_n = 1'b0;
    logic       chan_clk = 1'b0;
    logic       sys_clk = 1'b0;
    logic [7:0] chan_data = 8'h00;
    logic       chan_qual = 1'b0;
    logic       chan_sos = 1'b0;
    logic       cfg_qual_high = 1'b1;
    logic       mem_full = 1'b0;
    logic       ovf_clear = 1'b0;
    logic       out_ready = 1'b0;
    logic       chan_req, ovf_flag, out_valid, out_sos;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model: 0 hunt, 1 pass, 2 skip
    int         mst = 0;
    logic [8:0] mq[$];

    always #5 sys_clk = ~sys_clk;
    always #7 chan_clk = ~chan_clk;

    sector_chan_port i_sector_chan_port (
        .rst_n(rst_n), .chan_clk(chan_clk), .chan_data(chan_data),
        .chan_qual(chan_qual), .chan_sos(chan_sos), .chan_req(chan_req),
        .sys_clk(sys_clk), .cfg_qual_high(cfg_qual_high), .mem_full(mem_full),
        .ovf_clear(ovf_clear), .ovf_flag(ovf_flag), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sos(out_sos)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chan_cycle(input logic [7:0] d, input logic q, input logic s);
        bit acc;
        @(negedge chan_clk);
        chan_data = d; chan_qual = q; chan_sos = s;
        @(posedge chan_clk);
        acc = (q == cfg_qual_high);
        if (acc) begin
            if (mq.size() >= 64) begin
                if (mst == 1) mst = 2;
            end else if (mst == 1) begin
                mq.push_back({s, d});
            end else if (s) begin
                mq.push_back({s, d});
                mst = 1;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge chan_clk);
            chan_data = 8'hEE; chan_qual = ~cfg_qual_high; chan_sos = 1'b0;
            @(posedge chan_clk);
        end
    endtask

    task automatic drain(input string rq);
        int idl = 0;
        logic [8:0] e;
        @(negedge sys_clk);
        out_ready = 1'b1;
        while (idl < 30) begin
            if (out_valid) begin
                idl = 0;
                if (mq.size() == 0) begin
                    check(0, rq, int'({out_sos, out_data}), -1);
                end else begin
                    e = mq.pop_front();
                    check({out_sos, out_data} == e, rq, int'({out_sos, out_data}), int'(e));
                end
            end else begin
                idl++;
            end
            @(negedge sys_clk);
        end
        out_ready = 1'b0;
        check(mq.size() == 0, rq, mq.size(), 0);
        idle(10);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [8:0] s1, s2;
        chan_qual = 1'b0;
        repeat (5) @(negedge sys_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        // R10 reset state
        check(out_valid == 1'b0, "R10", out_valid, 0);
        check(ovf_flag == 1'b0, "R10", ovf_flag, 0);
        check(chan_req == 1'b1, "R10", chan_req, 1);

        // R2: bytes before the first sector start are discarded
        idle(2);
        for (int i = 0; i < 5; i++) chan_cycle(8'h10 + 8'(i), 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            chan_cycle(8'hA0 + 8'(i), 1'b1, i == 0);
            chan_cycle(8'h33, 1'b0, 1'b1); // inactive qualifier, R1
        end
        idle(5);
        drain("R2");

        // R1 / R3: polarity sweep with mixed qualifier patterns
        for (int pol = 0; pol < 2; pol++) begin
            @(negedge chan_clk);
            cfg_qual_high = pol[0]; chan_qual = ~pol[0];
            idle(2);
            for (int i = 0; i < 24; i++) begin
                logic q;
                q = (i % 3 != 0 || i == 0) ? pol[0] : ~pol[0];
                chan_cycle(8'((pol * 24 + i) * 7) ^ 8'h5A, q, (i == 0 || i == 12));
            end
            idle(5);
            drain("R1");
        end

        // R7: high-water mark sweep over occupancy 1..64
        @(negedge chan_clk);
        cfg_qual_high = 1'b1; chan_qual = 1'b0;
        idle(2);
        for (int i = 0; i < 64; i++) begin
            chan_cycle(8'(i), 1'b1, i == 0);
            idle(2);
            @(negedge chan_clk);
            check(chan_req == (mq.size() < 60), "R7", chan_req, int'(mq.size() < 60));
        end

        // R4: bytes beyond 64 are dropped and raise the flag
        for (int i = 64; i < 70; i++) chan_cycle(8'(i), 1'b1, 1'b0);
        idle(3);
        repeat (10) @(negedge sys_clk);
        check(ovf_flag == 1'b1, "R4", ovf_flag, 1);

        // R9: output holds while not taken
        s1 = {out_sos, out_data};
        check(out_valid == 1'b1, "R9", out_valid, 1);
        repeat (5) @(negedge sys_clk);
        s2 = {out_sos, out_data};
        check(out_valid == 1'b1 && s1 == s2, "R9", int'(s2), int'(s1));
        check(s1 == mq[0], "R9", int'(s1), int'(mq[0]));
        drain("R4");

        // R5: rest of damaged sector skipped, next sector stored
        for (int i = 0; i < 3; i++) chan_cycle(8'h90 + 8'(i), 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) chan_cycle(8'hC0 + 8'(i), 1'b1, i == 0);
        idle(5);
        check(mq.size() == 4, "R5", mq.size(), 4);
        drain("R5");

        // R6: sticky until cleared
        check(ovf_flag == 1'b1, "R6", ovf_flag, 1);
        @(negedge sys_clk); ovf_clear = 1'b1;
        @(negedge sys_clk); ovf_clear = 1'b0;
        repeat (20) @(negedge sys_clk);
        check(ovf_flag == 1'b0, "R6", ovf_flag, 0);

        // R8: downstream full forces request low
        @(negedge sys_clk); mem_full = 1'b1;
        idle(5);
        @(negedge chan_clk);
        check(chan_req == 1'b0, "R8", chan_req, 0);
        @(negedge sys_clk); mem_full = 1'b0;
        idle(5);
        @(negedge chan_clk);
        check(chan_req == 1'b1, "R8", chan_req, 1);

        done = 1;
        summary();
        $finish;
    end
endmodule